// File: doc/BRIEF.md
# Banked Host Register Front End

This block is the register front end that a host processor sees on a network controller. The host reaches sixteen register slots through a 4-bit address, a read strobe and a write strobe. The bus can work one byte at a time or one 16-bit word at a time. Slots 0 to 7 are fixed registers. Slots 8 to 15 are steered to one of three register sets by a 2-bit bank field in the configuration register. Slot 6 is a control register. Its top bit holds the transmitter and receiver in the disabled state. Slot 7 is the configuration register. It carries identification bits, a powerdown control, a pin-polarity bit, the bank field and a byte-order bit.

Bank code 01 also contains the buffer data port at slots 8 and 9. The buffer behind this port is modelled as a byte FIFO. In word mode, each port access moves two buffer bytes. The byte-order bit decides which bus lane carries the first of the two. The banked sets and the low registers are plain storage.

Top module: `hostreg_front`

## Requirements
- R1: After reset, a word read at slot 6 returns E0B6 hex, with the ready-polarity pin low. Slot 6 resets to B6 hex, with bit 7 set (transmitter and receiver held off).
- R2: Slots 0 to 5 are plain read/write storage, and the bank field has no effect on them.
- R3: Slots 8 to 15 reach a separate register set for each bank code 00, 01 and 11. A value written under one code is still there when that code is selected again.
- R4: Bank code 10 is reserved. Reads of slots 8 to 15 return zero, and writes change no set.
- R5: Slot 7 layout is: bits 7:6 read-only 1, bit 5 power (1 = powered), bit 4 read-only copy of the ready-polarity pin, bits 3:2 bank, bit 1 polarity, bit 0 byte order. Writes to bits 7:6 and 4 have no effect.
- R6: Writing 0 to bit 5 while slot 6 bit 7 is 1 enters powerdown: `pwr_on` goes low and bit 5 reads 0. Writing 1 leaves powerdown, and so does synchronous reset.
- R7: A write of 0 to bit 5 while slot 6 bit 7 is 0 leaves the power state unchanged. The gate uses the slot 6 value from before the write.
- R8: During powerdown, register contents are kept, and the low and banked registers can still be read and written.
- R9: During powerdown, buffer port reads return zero and pop nothing, and buffer port writes are dropped.
- R10: In word mode with byte order 0, the first buffer byte is on `wdata[7:0]`/`rdata[7:0]`. With byte order 1, it is on bits 15:8. This holds for pushes and for pops.
- R11: In byte mode, each port access at slot 8 or 9 moves one byte on bits 7:0, in FIFO order, and the byte-order bit has no effect.
- R12: In word mode, slot 2k sits on the low lane and slot 2k+1 on the high lane (the address LSB is ignored). In byte mode, bits 15:8 read 0. When `rd_stb` is low, `rdata` is 0.
- R13: A port push without room for all its bytes is dropped. A port read with fewer stored bytes than it needs returns zero and pops nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_word | input | 1 | 1 = 16-bit word access, 0 = byte access |
| addr | input | 4 | Register slot address |
| rd_stb | input | 1 | Read strobe; a port read pops on the edge |
| wr_stb | input | 1 | Write strobe; the write lands on the edge |
| wdata | input | 16 | Write data |
| rdy_pol_pin | input | 1 | Ready-polarity strap pin, visible in slot 7 bit 4 |
| rdata | output | 16 | Combinational read data |
| pwr_on | output | 1 | 1 = powered, 0 = powerdown |

## Verification
Read data is combinational from the address, the bank field and the stored state. The bench therefore samples `rdata` in the same cycle the read is driven, a few nanoseconds after the falling-edge drive and before the next rising edge. Writes, FIFO pushes and pops, and power-state changes land on the rising edge where the strobe is high. Their effects are checked only from the following cycle onward: by a later read, or by sampling `pwr_on` after the edge. Reset exit of powerdown is checked after the first clean edge with reset released.

// File: rtl/hrf_pkg.sv
package hrf_pkg;

    localparam int BYTE_W   = 8;
    localparam int HALT_BIT = 7;
    localparam int N_SETS   = 3;

    typedef enum logic [1:0] {
        BANK_MAIN  = 2'b00,
        BANK_ALT_A = 2'b01,
        BANK_RSV   = 2'b10,
        BANK_ALT_B = 2'b11
    } bank_e;

    typedef struct packed {
        logic  pwr_on;
        bank_e bank;
        logic  pol_hi;
        logic  hi_first;
    } cfg_t;

    function automatic bank_e set_code(input int k);
        case (k)
            0:       return BANK_MAIN;
            1:       return BANK_ALT_A;
            default: return BANK_ALT_B;
        endcase
    endfunction

    function automatic logic [15:0] lane_order(input logic hi_first,
                                               input logic [7:0] first,
                                               input logic [7:0] second);
        return hi_first ? {first, second} : {second, first};
    endfunction

    function automatic logic [7:0] cfg_byte(input cfg_t c, input logic pin);
        return {2'b11, c.pwr_on, pin, c.bank, c.pol_hi, c.hi_first};
    endfunction

endpackage

// File: rtl/hrf_regfile.sv
module hrf_regfile #(
    parameter int         N       = 8,
    parameter logic [7:0] RST_VAL = 8'h00
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        we,
    input  logic [N-1:0][7:0]   wd,
    output logic [N-1:0][7:0]   q
);
    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)        q[i] <= RST_VAL;
            else if (we[i]) q[i] <= wd[i];
        end
    end
endmodule

// File: rtl/hrf_cfg.sv
module hrf_cfg
    import hrf_pkg::*;
#(
    parameter logic [7:0] CTL_RST = 8'hB6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we_ctl,
    input  logic [7:0] ctl_wd,
    input  logic       we_cfg,
    input  logic       wr_pwr,
    input  logic [1:0] wr_bank,
    input  logic       wr_pol,
    input  logic       wr_ord,
    output logic [7:0] ctl_q,
    output cfg_t       cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= CTL_RST;
        else if (we_ctl) ctl_q <= ctl_wd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{pwr_on: 1'b1, bank: BANK_MAIN, pol_hi: 1'b0, hi_first: 1'b0};
        end else if (we_cfg) begin
            cfg_q.bank     <= bank_e'(wr_bank);
            cfg_q.pol_hi   <= wr_pol;
            cfg_q.hi_first <= wr_ord;
            if (wr_pwr)              cfg_q.pwr_on <= 1'b1;
            else if (ctl_q[HALT_BIT]) cfg_q.pwr_on <= 1'b0;
        end
    end

    // R6
    pd_entry_gated_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_q.pwr_on) |-> $past(ctl_q[HALT_BIT]) && $past(we_cfg));

    // R7
    pwr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we_cfg |=> $stable(cfg_q.pwr_on));
endmodule

// File: rtl/hrf_fifo.sv
module hrf_fifo #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    push_n,
    input  logic [7:0]    din0,
    input  logic [7:0]    din1,
    input  logic [1:0]    pop_n,
    output logic [7:0]    dout0,
    output logic [7:0]    dout1,
    output logic [LW-1:0] level
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;

    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[wp] <= din0;
        if (push_n == 2'd2) mem[wp + AW'(1)] <= din1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            wp    <= wp + AW'(push_n);
            rp    <= rp + AW'(pop_n);
            level <= level + LW'(push_n) - LW'(pop_n);
        end
    end

    assign dout0 = mem[rp];
    assign dout1 = mem[rp + AW'(1)];

    // R13
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

    // R13
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        LW'(pop_n) <= level);

    // R13
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        LW'(push_n) <= LW'(DEPTH) - level);
endmodule

// File: rtl/hostreg_front.sv
module hostreg_front
    import hrf_pkg::*;
#(
    parameter int BUF_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_word,
    input  logic [3:0]  addr,
    input  logic        rd_stb,
    input  logic        wr_stb,
    input  logic [15:0] wdata,
    input  logic        rdy_pol_pin,
    output logic [15:0] rdata,
    output logic        pwr_on
);
    localparam int LW     = $clog2(BUF_DEPTH + 1);
    localparam int N_LOW  = 6;
    localparam int N_BANK = 8;

    logic [15:0]                    hit;
    logic [15:0][7:0]               wbyte;
    logic [15:0][7:0]               view;
    logic [N_LOW-1:0][7:0]          low_q;
    logic [N_SETS-1:0][N_BANK-1:0]  set_we;
    logic [N_SETS-1:0][N_BANK-1:0][7:0] set_q;
    logic [7:0]                     ctl_q;
    cfg_t                           cfg;

    // write decode: word mode covers the even/odd slot pair
    always_comb begin
        for (int r = 0; r < 16; r++) begin
            hit[r]   = wr_stb && (bus_word ? (4'(r) >> 1) == (addr >> 1) : 4'(r) == addr);
            wbyte[r] = (bus_word && r[0]) ? wdata[15:8] : wdata[7:0];
        end
    end

    logic is_port;
    assign is_port = (cfg.bank == BANK_ALT_A) && (addr[3:1] == 3'b100);

    always_comb begin
        for (int k = 0; k < N_SETS; k++)
            for (int i = 0; i < N_BANK; i++)
                set_we[k][i] = hit[8+i] && (cfg.bank == set_code(k)) && !(k == 1 && i < 2);
    end

    hrf_regfile #(.N(N_LOW)) u_low (
        .clk(clk), .rst(rst), .we(hit[N_LOW-1:0]), .wd(wbyte[N_LOW-1:0]), .q(low_q)
    );

    for (genvar k = 0; k < N_SETS; k++) begin : g_set
        hrf_regfile #(.N(N_BANK)) u_set (
            .clk(clk), .rst(rst), .we(set_we[k]), .wd(wbyte[15:8]), .q(set_q[k])
        );
    end

    hrf_cfg u_cfg (
        .clk(clk), .rst(rst),
        .we_ctl(hit[6]), .ctl_wd(wbyte[6]),
        .we_cfg(hit[7]), .wr_pwr(wbyte[7][5]), .wr_bank(wbyte[7][3:2]),
        .wr_pol(wbyte[7][1]), .wr_ord(wbyte[7][0]),
        .ctl_q(ctl_q), .cfg_q(cfg)
    );
    assign pwr_on = cfg.pwr_on;

    // buffer data port
    logic [LW-1:0] level, need;
    logic [1:0]    push_n, pop_n;
    logic [7:0]    dout0, dout1, din0, din1;
    logic          port_rd_ok, port_wr_ok;
    logic [15:0]   port_data;

    assign need       = bus_word ? LW'(2) : LW'(1);
    assign port_rd_ok = rd_stb && is_port && cfg.pwr_on && (level >= need);
    assign port_wr_ok = wr_stb && is_port && cfg.pwr_on && ((LW'(BUF_DEPTH) - level) >= need);
    assign pop_n      = port_rd_ok ? need[1:0] : 2'd0;
    assign push_n     = port_wr_ok ? need[1:0] : 2'd0;
    assign din0       = (bus_word && cfg.hi_first) ? wdata[15:8] : wdata[7:0];
    assign din1       = cfg.hi_first ? wdata[7:0] : wdata[15:8];
    assign port_data  = !port_rd_ok ? 16'h0000 :
                        bus_word ? lane_order(cfg.hi_first, dout0, dout1) : {8'h00, dout0};

    hrf_fifo #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .rst(rst), .push_n(push_n), .din0(din0), .din1(din1),
        .pop_n(pop_n), .dout0(dout0), .dout1(dout1), .level(level)
    );

    // read path
    always_comb begin
        for (int r = 0; r < N_LOW; r++) view[r] = low_q[r];
        view[6] = ctl_q;
        view[7] = cfg_byte(cfg, rdy_pol_pin);
        for (int i = 0; i < N_BANK; i++) begin
            case (cfg.bank)
                BANK_MAIN:  view[8+i] = set_q[0][i];
                BANK_ALT_A: view[8+i] = set_q[1][i];
                BANK_ALT_B: view[8+i] = set_q[2][i];
                default:    view[8+i] = 8'h00;
            endcase
        end
    end

    logic [3:0]  base;
    logic [15:0] reg_data;
    assign base     = bus_word ? {addr[3:1], 1'b0} : addr;
    assign reg_data = bus_word ? {view[base | 4'd1], view[base]} : {8'h00, view[addr]};
    assign rdata    = !rd_stb ? 16'h0000 : (is_port ? port_data : reg_data);

    // R4
    rsv_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb && (cfg.bank == BANK_RSV) |=> $stable(set_q));

    // R9
    pd_port_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.pwr_on && is_port |=> $stable(level));
endmodule

// File: tb/hostreg_front_tb.sv
`timescale 1ns/1ps
module hostreg_front_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_word = 1'b0;
    logic [3:0]  addr = '0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wdata = '0;
    logic        rdy_pol_pin = 1'b0;
    logic [15:0] rdata;
    logic        pwr_on;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    hostreg_front dut_i (
        .clk(clk), .rst(rst), .bus_word(bus_word), .addr(addr), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wdata(wdata), .rdy_pol_pin(rdy_pol_pin),
        .rdata(rdata), .pwr_on(pwr_on)
    );

    typedef struct packed {
        logic        rd;
        logic        word;
        logic [3:0]  addr;
        logic [15:0] data;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 59;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,4'h6,16'h0000,16'hE0B6,4'd1},   // R1 reset image
        '{1'b0,1'b0,4'h0,16'h0011,16'h0000,4'd0},
        '{1'b0,1'b0,4'h5,16'h0055,16'h0000,4'd0},
        '{1'b1,1'b1,4'h4,16'h0000,16'h5500,4'd12},  // R12 lane layout
        '{1'b1,1'b0,4'h0,16'h0000,16'h0011,4'd2},   // R2
        '{1'b0,1'b1,4'h2,16'hA1B2,16'h0000,4'd0},
        '{1'b1,1'b0,4'h3,16'h0000,16'h00A1,4'd12},  // R12
        '{1'b0,1'b1,4'h8,16'h1234,16'h0000,4'd0},
        '{1'b0,1'b0,4'h7,16'h0024,16'h0000,4'd0},
        '{1'b0,1'b1,4'hA,16'h5678,16'h0000,4'd0},
        '{1'b0,1'b0,4'h7,16'h002C,16'h0000,4'd0},
        '{1'b0,1'b1,4'h8,16'h9ABC,16'h0000,4'd0},
        '{1'b1,1'b1,4'h8,16'h0000,16'h9ABC,4'd3},   // R3
        '{1'b1,1'b0,4'h0,16'h0000,16'h0011,4'd2},   // R2 bank-independent
        '{1'b0,1'b0,4'h7,16'h0028,16'h0000,4'd0},
        '{1'b1,1'b1,4'h8,16'h0000,16'h0000,4'd4},   // R4 reads zero
        '{1'b0,1'b1,4'h8,16'hFFFF,16'h0000,4'd0},
        '{1'b1,1'b0,4'h7,16'h0000,16'h00E8,4'd5},   // R5
        '{1'b0,1'b0,4'h7,16'h0020,16'h0000,4'd0},
        '{1'b1,1'b1,4'h8,16'h0000,16'h1234,4'd3},   // R3
        '{1'b0,1'b0,4'h7,16'h002C,16'h0000,4'd0},
        '{1'b1,1'b1,4'h8,16'h0000,16'h9ABC,4'd4},   // R4 write ignored
        '{1'b0,1'b0,4'h7,16'h0034,16'h0000,4'd0},
        '{1'b1,1'b0,4'h7,16'h0000,16'h00E4,4'd5},   // R5 RO bits
        '{1'b1,1'b1,4'hA,16'h0000,16'h5678,4'd3},   // R3
        '{1'b0,1'b1,4'h8,16'h2211,16'h0000,4'd0},
        '{1'b0,1'b0,4'h7,16'h0025,16'h0000,4'd0},
        '{1'b1,1'b1,4'h8,16'h0000,16'h1122,4'd10},  // R10
        '{1'b0,1'b1,4'h9,16'h3344,16'h0000,4'd0},
        '{1'b0,1'b0,4'h7,16'h0024,16'h0000,4'd0},
        '{1'b1,1'b1,4'h8,16'h0000,16'h4433,4'd10},  // R10
        '{1'b1,1'b1,4'h8,16'h0000,16'h0000,4'd13},  // R13 empty
        '{1'b0,1'b0,4'h8,16'h005A,16'h0000,4'd0},
        '{1'b0,1'b0,4'h9,16'h006B,16'h0000,4'd0},
        '{1'b1,1'b1,4'h8,16'h0000,16'h6B5A,4'd11},  // R11
        '{1'b0,1'b0,4'h7,16'h0025,16'h0000,4'd0},
        '{1'b0,1'b0,4'h8,16'h0001,16'h0000,4'd0},
        '{1'b0,1'b0,4'h8,16'h0002,16'h0000,4'd0},
        '{1'b1,1'b0,4'h8,16'h0000,16'h0001,4'd11},  // R11
        '{1'b1,1'b0,4'h9,16'h0000,16'h0002,4'd11},  // R11
        '{1'b1,1'b0,4'h8,16'h0000,16'h0000,4'd13},  // R13
        '{1'b0,1'b0,4'h7,16'h0024,16'h0000,4'd0},
        '{1'b0,1'b0,4'h6,16'h0036,16'h0000,4'd0},
        '{1'b0,1'b0,4'h7,16'h0004,16'h0000,4'd0},
        '{1'b1,1'b0,4'h7,16'h0000,16'h00E4,4'd7},   // R7 refused
        '{1'b0,1'b1,4'h8,16'hBEEF,16'h0000,4'd0},
        '{1'b0,1'b0,4'h6,16'h00B6,16'h0000,4'd0},
        '{1'b0,1'b0,4'h7,16'h0004,16'h0000,4'd0},
        '{1'b1,1'b0,4'h7,16'h0000,16'h00C4,4'd6},   // R6 entered
        '{1'b1,1'b0,4'h0,16'h0000,16'h0011,4'd8},   // R8
        '{1'b0,1'b0,4'h1,16'h0077,16'h0000,4'd0},
        '{1'b1,1'b0,4'h1,16'h0000,16'h0077,4'd8},   // R8
        '{1'b1,1'b1,4'hA,16'h0000,16'h5678,4'd8},   // R8
        '{1'b0,1'b1,4'h8,16'hAAAA,16'h0000,4'd0},
        '{1'b1,1'b1,4'h8,16'h0000,16'h0000,4'd9},   // R9
        '{1'b0,1'b0,4'h7,16'h0024,16'h0000,4'd0},
        '{1'b1,1'b0,4'h7,16'h0000,16'h00E4,4'd6},   // R6 exit
        '{1'b1,1'b1,4'h8,16'h0000,16'hBEEF,4'd9},   // R9 no pop
        '{1'b1,1'b1,4'h8,16'h0000,16'h0000,4'd9}    // R9 write dropped
    };

    task automatic check(input logic ok, input int req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic word, input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_word = word; addr = a; wdata = d; wr_stb = 1'b1;
        @(posedge clk); #1;
        wr_stb = 1'b0;
    endtask

    task automatic bus_rd(input logic word, input logic [3:0] a, input logic [15:0] exp,
                          input int req);
        @(negedge clk);
        bus_word = word; addr = a; rd_stb = 1'b1;
        #3;
        check(rdata === exp, req, rdata, exp);
        @(posedge clk); #1;
        rd_stb = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        bus_word = 1'b1; addr = 4'h6;
        #3;
        check(pwr_on === 1'b1, 6, {15'd0, pwr_on}, 16'h0001);   // R6 reset state
        check(rdata === 16'h0000, 12, rdata, 16'h0000);         // R12 idle read

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) bus_rd(VECS[i].word, VECS[i].addr, VECS[i].exp, int'(VECS[i].req));
            else            bus_wr(VECS[i].word, VECS[i].addr, VECS[i].data);
        end

        // R5: pin mirrored in bit 4
        rdy_pol_pin = 1'b1;
        bus_rd(1'b0, 4'h7, 16'h00F4, 5);
        rdy_pol_pin = 1'b0;

        // R13: fill 16 bytes, extra push dropped, drain, then empty read
        for (int k = 0; k < 8; k++) bus_wr(1'b1, 4'h8, {8'(k + 8'h10), 8'(k)});
        bus_wr(1'b1, 4'h8, 16'hDEAD);
        for (int k = 0; k < 8; k++) bus_rd(1'b1, 4'h8, {8'(k + 8'h10), 8'(k)}, 13);
        bus_rd(1'b1, 4'h8, 16'h0000, 13);

        // R6: pin-level powerdown and reset exit
        bus_wr(1'b0, 4'h7, 16'h0004);
        check(pwr_on === 1'b0, 6, {15'd0, pwr_on}, 16'h0000);
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        check(pwr_on === 1'b1, 6, {15'd0, pwr_on}, 16'h0001);
        bus_rd(1'b1, 4'h6, 16'hE0B6, 1);   // R1 after second reset

        done = 1'b1;
        finish_run();
    end
endmodule